// File: doc/BRIEF.md
# Register-Bus to Stream Packet FIFO

This block connects a simple single-beat 32-bit register bus to two AXI4-Stream ports: one sends frames out, one takes frames in. To send a frame, software sets a 4-bit destination, pushes the payload as 32-bit words and then writes the frame size in bytes. That length write commits the frame. The block then drives it onto the outgoing stream with TKEEP, TLAST and TDEST.

Incoming frames are stored word by word. Software sees only frames that have fully arrived. It polls the occupancy, reads the length (which pops the frame descriptor and latches that frame's destination), then reads the payload words. A status register (write-1-to-clear) with an enable mask drives one interrupt line. Each channel has a keyed flush, and a stream-wide reset flushes both channels and sends a one-cycle reset pulse downstream.

Register word addresses: 0 status, 1 interrupt enable, 2 send flush, 3 send data, 4 send vacancy, 5 send length, 6 send destination, 7 receive flush, 8 receive occupancy, 9 receive data, 10 receive length, 11 receive destination, 12 stream reset.

Top module: `mmstream_fifo`

## Requirements
- R1: A write of a nonzero byte count N to address 5 sends ceil(N/4) queued words in write order. Each beat carries as tdest the low 4 bits last written to address 6, which read back from address 6. A write of zero sends nothing.
- R2: Every beat but the last has tkeep 4'hF. The last beat has tlast and keeps the lowest lanes: tkeep is 4'h1, 4'h3, 4'h7 or 4'hF for N mod 4 = 1, 2, 3, 0.
- R3: Counts are in 32-bit words. Address 4 reads DATA_DEPTH minus the words queued for sending. Address 8 reads the words of completely received frames only, so a frame without its tlast beat is not counted.
- R4: A write to address 3 while vacancy is zero drops the word and sets status bit 5 (send overrun).
- R5: A read of address 10 pops the oldest received frame's byte count (the sum of its tkeep bits) and latches its tdest for address 11. Reads of address 9 return that frame's words in arrival order.
- R6: A read of address 9 with occupancy zero, or of address 10 with no frame stored, returns 0 and sets status bit 4 (receive underrun).
- R7: Status bit 0 is set when a sent frame's tlast beat is accepted, and bit 1 when an incoming tlast beat is stored. Writing ones to address 0 clears those bits. When a set and a clear hit the same bit in one cycle, the set wins.
- R8: irq is high exactly when the status bits ANDed with the enable bits at address 1 are nonzero.
- R9: Writing 0x000000A5 to address 2 (or address 7) discards all words and frames of the send (or receive) channel only and sets status bit 2 (or bit 3). Any other value has no effect.
- R10: Writing 0x000000A5 to address 12 flushes both channels, sets status bits 2 and 3, and drives peer_rst high for exactly one cycle.
- R11: While tx_tvalid is high and tx_tready low, tx_tvalid and every tx payload signal hold their values, unless a send flush occurs.
- R12: Read data for a bus_rd strobe appears on bus_rdata after the next clock edge. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq | output | 1 | Interrupt request |
| tx_tvalid | output | 1 | Outgoing stream valid |
| tx_tready | input | 1 | Outgoing stream ready |
| tx_tdata | output | 32 | Outgoing stream data |
| tx_tkeep | output | 4 | Outgoing byte qualifiers |
| tx_tlast | output | 1 | Outgoing frame end |
| tx_tdest | output | 4 | Outgoing destination |
| rx_tvalid | input | 1 | Incoming stream valid |
| rx_tready | output | 1 | Incoming stream ready |
| rx_tdata | input | 32 | Incoming stream data |
| rx_tkeep | input | 4 | Incoming byte qualifiers |
| rx_tlast | input | 1 | Incoming frame end |
| rx_tdest | input | 4 | Incoming destination |
| peer_rst | output | 1 | One-cycle reset pulse to the downstream device |

## Verification
A read strobe driven after edge k gives data on bus_rdata after edge k+1, and the bench samples it 1 ns after that edge. A length write captured at edge k loads the sender at edge k+1, so the first beat can complete at edge k+2. The bench samples stream beats at the falling edge, after driving inputs 1 ns past the rising edge, and it counts beats only after a settle window. Status bits, occupancy and flush effects land on the edge that captures their event, so the bench reads them back with a following bus read and never in the same cycle.

// File: rtl/mmstream_pkg.sv
package mmstream_pkg;

  localparam int REG_AW = 4;
  localparam int ST_W   = 6;

  typedef enum logic [REG_AW-1:0] {
    RA_STAT    = 4'd0,
    RA_IEN     = 4'd1,
    RA_TXFLUSH = 4'd2,
    RA_TXDATA  = 4'd3,
    RA_TXVAC   = 4'd4,
    RA_TXLEN   = 4'd5,
    RA_TXDEST  = 4'd6,
    RA_RXFLUSH = 4'd7,
    RA_RXOCC   = 4'd8,
    RA_RXDATA  = 4'd9,
    RA_RXLEN   = 4'd10,
    RA_RXDEST  = 4'd11,
    RA_STRMRST = 4'd12
  } reg_addr_e;

  // status bit positions
  localparam int SB_TXDONE = 0;
  localparam int SB_RXDONE = 1;
  localparam int SB_TXRST  = 2;
  localparam int SB_RXRST  = 3;
  localparam int SB_RXUND  = 4;
  localparam int SB_TXOVR  = 5;

  localparam logic [31:0] FLUSH_KEY = 32'h0000_00A5;

  // byte-lane mask of a closing beat from the length remainder
  function automatic logic [3:0] tail_keep(input logic [1:0] rem);
    case (rem)
      2'd1:    tail_keep = 4'h1;
      2'd2:    tail_keep = 4'h3;
      2'd3:    tail_keep = 4'h7;
      default: tail_keep = 4'hF;
    endcase
  endfunction

endpackage

// File: rtl/mms_fifo.sv
module mms_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push,
  input  logic [W-1:0]               wdata,
  input  logic                       pop,
  output logic [W-1:0]               rdata,
  output logic [$clog2(DEPTH):0]     count,
  output logic                       full,
  output logic                       empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push_ok, pop_ok;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign rdata   = mem[rp_q];
  assign count   = cnt_q;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (push_ok) wp_d = wp_q + AW'(1);
      if (pop_ok)  rp_d = rp_q + AW'(1);
      cnt_d = cnt_q + CW'(push_ok) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wp_q] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/mms_tx_engine.sv
module mms_tx_engine
  import mmstream_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             len_wr,
  input  logic [LEN_W-1:0] len_in,
  input  logic [3:0]       dest_in,
  input  logic             fifo_empty,
  input  logic [31:0]      fifo_data,
  output logic             fifo_pop,
  output logic             tvalid,
  input  logic             tready,
  output logic [31:0]      tdata,
  output logic [3:0]       tkeep,
  output logic             tlast,
  output logic [3:0]       tdest,
  output logic             done
);
  localparam int BW = LEN_W - 1;

  logic             pend_v_q, pend_v_d;
  logic [LEN_W-1:0] pend_len_q, pend_len_d;
  logic [3:0]       pend_dest_q, pend_dest_d;
  logic             act_q, act_d;
  logic [BW-1:0]    beats_q, beats_d;
  logic [1:0]       rem_q, rem_d;
  logic [3:0]       dest_q, dest_d;
  logic [LEN_W:0]   len_round;
  logic             accept, load, beat, last;

  assign len_round = {1'b0, pend_len_q} + (LEN_W+1)'(3);
  assign accept    = len_wr && !pend_v_q && (len_in != '0);
  assign load      = pend_v_q && !act_q;
  assign last      = (beats_q == BW'(1));
  assign tvalid    = act_q && !fifo_empty;
  assign beat      = tvalid && tready;
  assign fifo_pop  = beat;
  assign tdata     = fifo_data;
  assign tlast     = last;
  assign tkeep     = last ? tail_keep(rem_q) : 4'hF;
  assign tdest     = dest_q;
  assign done      = beat && last;

  always_comb begin
    pend_v_d    = pend_v_q;
    pend_len_d  = pend_len_q;
    pend_dest_d = pend_dest_q;
    act_d       = act_q;
    beats_d     = beats_q;
    rem_d       = rem_q;
    dest_d      = dest_q;
    if (flush) begin
      pend_v_d = 1'b0;
      act_d    = 1'b0;
    end else begin
      if (load) begin
        pend_v_d = 1'b0;
        act_d    = 1'b1;
        beats_d  = len_round[LEN_W:2];
        rem_d    = pend_len_q[1:0];
        dest_d   = pend_dest_q;
      end else if (beat) begin
        beats_d = beats_q - BW'(1);
        if (last) act_d = 1'b0;
      end
      if (accept) begin
        pend_v_d    = 1'b1;
        pend_len_d  = len_in;
        pend_dest_d = dest_in;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v_q    <= 1'b0;
      pend_len_q  <= '0;
      pend_dest_q <= '0;
      act_q       <= 1'b0;
      beats_q     <= '0;
      rem_q       <= '0;
      dest_q      <= '0;
    end else begin
      pend_v_q    <= pend_v_d;
      pend_len_q  <= pend_len_d;
      pend_dest_q <= pend_dest_d;
      act_q       <= act_d;
      beats_q     <= beats_d;
      rem_q       <= rem_d;
      dest_q      <= dest_d;
    end
  end

endmodule

// File: rtl/mms_rx_engine.sv
module mms_rx_engine #(
  parameter int LEN_W = 16,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             tvalid,
  output logic             tready,
  input  logic [3:0]       tkeep,
  input  logic             tlast,
  input  logic             data_full,
  input  logic             info_full,
  output logic             push,
  output logic             commit,
  output logic [CNT_W-1:0] commit_beats,
  output logic [LEN_W-1:0] commit_len
);
  logic [LEN_W-1:0] bytes_q, bytes_d, bytes_sum;
  logic [CNT_W-1:0] beats_q, beats_d, beats_sum;

  assign tready       = !data_full && !info_full;
  assign push         = tvalid && tready;
  assign commit       = push && tlast;
  assign bytes_sum    = bytes_q + LEN_W'($countones(tkeep));
  assign beats_sum    = beats_q + CNT_W'(1);
  assign commit_len   = bytes_sum;
  assign commit_beats = beats_sum;

  always_comb begin
    bytes_d = bytes_q;
    beats_d = beats_q;
    if (flush || commit) begin
      bytes_d = '0;
      beats_d = '0;
    end else if (push) begin
      bytes_d = bytes_sum;
      beats_d = beats_sum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bytes_q <= '0;
      beats_q <= '0;
    end else begin
      bytes_q <= bytes_d;
      beats_q <= beats_d;
    end
  end

endmodule

// File: rtl/mmstream_fifo.sv
module mmstream_fifo
  import mmstream_pkg::*;
#(
  parameter int DATA_DEPTH = 16,
  parameter int INFO_DEPTH = 4,
  parameter int LEN_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              tx_tvalid,
  input  logic              tx_tready,
  output logic [31:0]       tx_tdata,
  output logic [3:0]        tx_tkeep,
  output logic              tx_tlast,
  output logic [3:0]        tx_tdest,
  input  logic              rx_tvalid,
  output logic              rx_tready,
  input  logic [31:0]       rx_tdata,
  input  logic [3:0]        rx_tkeep,
  input  logic              rx_tlast,
  input  logic [3:0]        rx_tdest,
  output logic              peer_rst
);
  localparam int CNT_W  = $clog2(DATA_DEPTH) + 1;
  localparam int INFO_W = LEN_W + 4;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  reg_addr_e ra;
  assign ra = reg_addr_e'(bus_addr);

  logic wr_key, strm_key, tx_flush, rx_flush;
  assign wr_key   = bus_wr && (bus_wdata == FLUSH_KEY);
  assign strm_key = wr_key && (ra == RA_STRMRST);
  assign tx_flush = strm_key || (wr_key && (ra == RA_TXFLUSH));
  assign rx_flush = strm_key || (wr_key && (ra == RA_RXFLUSH));

  // ---------------- send channel ----------------
  logic             txf_push, txf_pop, txf_full, txf_empty, tx_ovr, tx_done;
  logic [31:0]      txf_head;
  logic [CNT_W-1:0] txf_cnt;
  logic [3:0]       tx_dest_q, tx_dest_d;

  assign txf_push = bus_wr && (ra == RA_TXDATA) && !txf_full;
  assign tx_ovr   = bus_wr && (ra == RA_TXDATA) && txf_full;
  assign tx_dest_d = (bus_wr && (ra == RA_TXDEST)) ? bus_wdata[3:0] : tx_dest_q;

  mms_fifo #(.W(32), .DEPTH(DATA_DEPTH)) i_txf (
    .clk(clk), .rst_n(rst_core_n), .flush(tx_flush),
    .push(txf_push), .wdata(bus_wdata), .pop(txf_pop), .rdata(txf_head),
    .count(txf_cnt), .full(txf_full), .empty(txf_empty)
  );

  mms_tx_engine #(.LEN_W(LEN_W)) i_txe (
    .clk(clk), .rst_n(rst_core_n), .flush(tx_flush),
    .len_wr(bus_wr && (ra == RA_TXLEN)), .len_in(bus_wdata[LEN_W-1:0]),
    .dest_in(tx_dest_q), .fifo_empty(txf_empty), .fifo_data(txf_head),
    .fifo_pop(txf_pop), .tvalid(tx_tvalid), .tready(tx_tready),
    .tdata(tx_tdata), .tkeep(tx_tkeep), .tlast(tx_tlast), .tdest(tx_tdest),
    .done(tx_done)
  );

  // ---------------- receive channel ----------------
  logic             rxf_push, rxf_full, rxf_empty, rx_commit_raw, rx_commit;
  logic [31:0]      rxf_head;
  logic [CNT_W-1:0] rxf_cnt, commit_beats;
  logic [LEN_W-1:0] commit_len;
  logic             inf_full, inf_empty;
  logic [INFO_W-1:0] inf_head;
  logic [$clog2(INFO_DEPTH):0] inf_cnt;
  logic             rxd_rd, rxd_ok, rxl_rd, rxl_ok, rx_und;
  logic [CNT_W-1:0] rx_occ_q, rx_occ_d;
  logic [3:0]       rx_dest_q, rx_dest_d;

  assign rxd_rd    = bus_rd && (ra == RA_RXDATA);
  assign rxd_ok    = rxd_rd && (rx_occ_q != '0);
  assign rxl_rd    = bus_rd && (ra == RA_RXLEN);
  assign rxl_ok    = rxl_rd && !inf_empty;
  assign rx_und    = (rxd_rd && !rxd_ok) || (rxl_rd && !rxl_ok);
  assign rx_commit = rx_commit_raw && !rx_flush;

  mms_rx_engine #(.LEN_W(LEN_W), .CNT_W(CNT_W)) i_rxe (
    .clk(clk), .rst_n(rst_core_n), .flush(rx_flush),
    .tvalid(rx_tvalid), .tready(rx_tready), .tkeep(rx_tkeep), .tlast(rx_tlast),
    .data_full(rxf_full), .info_full(inf_full), .push(rxf_push),
    .commit(rx_commit_raw), .commit_beats(commit_beats), .commit_len(commit_len)
  );

  mms_fifo #(.W(32), .DEPTH(DATA_DEPTH)) i_rxf (
    .clk(clk), .rst_n(rst_core_n), .flush(rx_flush),
    .push(rxf_push), .wdata(rx_tdata), .pop(rxd_ok), .rdata(rxf_head),
    .count(rxf_cnt), .full(rxf_full), .empty(rxf_empty)
  );

  mms_fifo #(.W(INFO_W), .DEPTH(INFO_DEPTH)) i_inf (
    .clk(clk), .rst_n(rst_core_n), .flush(rx_flush),
    .push(rx_commit_raw), .wdata({rx_tdest, commit_len}), .pop(rxl_ok),
    .rdata(inf_head), .count(inf_cnt), .full(inf_full), .empty(inf_empty)
  );

  always_comb begin
    rx_occ_d  = rx_occ_q;
    rx_dest_d = rx_dest_q;
    if (rx_flush) begin
      rx_occ_d  = '0;
      rx_dest_d = '0;
    end else begin
      rx_occ_d = rx_occ_q + (rx_commit ? commit_beats : '0) - CNT_W'(rxd_ok);
      if (rxl_ok) rx_dest_d = inf_head[INFO_W-1:LEN_W];
    end
  end

  // ---------------- status, enable, readback ----------------
  logic [ST_W-1:0] stat_q, stat_d, stat_set, ien_q, ien_d;
  logic [31:0]     rdata_d, rdata_q;
  logic            peer_rst_q;

  always_comb begin
    stat_set            = '0;
    stat_set[SB_TXDONE] = tx_done;
    stat_set[SB_RXDONE] = rx_commit;
    stat_set[SB_TXRST]  = tx_flush;
    stat_set[SB_RXRST]  = rx_flush;
    stat_set[SB_RXUND]  = rx_und;
    stat_set[SB_TXOVR]  = tx_ovr;
    stat_d = stat_q;
    if (bus_wr && (ra == RA_STAT)) stat_d = stat_q & ~bus_wdata[ST_W-1:0];
    stat_d = stat_d | stat_set;
    ien_d  = (bus_wr && (ra == RA_IEN)) ? bus_wdata[ST_W-1:0] : ien_q;
  end

  always_comb begin
    rdata_d = '0;
    case (ra)
      RA_STAT:   rdata_d = 32'(stat_q);
      RA_IEN:    rdata_d = 32'(ien_q);
      RA_TXVAC:  rdata_d = 32'(CNT_W'(DATA_DEPTH) - txf_cnt);
      RA_TXDEST: rdata_d = 32'(tx_dest_q);
      RA_RXOCC:  rdata_d = 32'(rx_occ_q);
      RA_RXDATA: rdata_d = rxd_ok ? rxf_head : '0;
      RA_RXLEN:  rdata_d = rxl_ok ? 32'(inf_head[LEN_W-1:0]) : '0;
      RA_RXDEST: rdata_d = 32'(rx_dest_q);
      default:   rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      tx_dest_q  <= '0;
      rx_occ_q   <= '0;
      rx_dest_q  <= '0;
      stat_q     <= '0;
      ien_q      <= '0;
      rdata_q    <= '0;
      peer_rst_q <= 1'b0;
    end else begin
      tx_dest_q  <= tx_dest_d;
      rx_occ_q   <= rx_occ_d;
      rx_dest_q  <= rx_dest_d;
      stat_q     <= stat_d;
      ien_q      <= ien_d;
      peer_rst_q <= strm_key;
      if (bus_rd) rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign peer_rst  = peer_rst_q;
  assign irq       = |(stat_q & ien_q);

endmodule

// File: rtl/mms_checker.sv
module mms_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        tx_tvalid,
  input logic        tx_tready,
  input logic [31:0] tx_tdata,
  input logic [3:0]  tx_tkeep,
  input logic        tx_tlast,
  input logic [3:0]  tx_tdest,
  input logic        tx_flush,
  input logic        irq,
  input logic [5:0]  ien,
  input logic [5:0]  stat,
  input logic        peer_rst,
  input logic        ovr_evt,
  input logic        und_rd,
  input logic [31:0] bus_rdata
);

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_tvalid && !tx_tready && !tx_flush) |=>
      (tx_tvalid && $stable(tx_tdata) && $stable(tx_tkeep) &&
       $stable(tx_tlast) && $stable(tx_tdest))); // R11

  AST_KEEP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_tvalid && !tx_tlast) |-> (tx_tkeep == 4'hF)); // R2

  AST_KEEP_LOWLANE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_tvalid |-> tx_tkeep[0]); // R2

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |-> !irq); // R8

  AST_PEER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    peer_rst |=> !peer_rst); // R10

  AST_OVERRUN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> stat[5]); // R4

  AST_UNDERRUN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    und_rd |=> (bus_rdata == 32'd0)); // R6

endmodule

bind mmstream_fifo mms_checker i_chk (
  .clk(clk), .rst_n(rst_core_n),
  .tx_tvalid(tx_tvalid), .tx_tready(tx_tready), .tx_tdata(tx_tdata),
  .tx_tkeep(tx_tkeep), .tx_tlast(tx_tlast), .tx_tdest(tx_tdest),
  .tx_flush(tx_flush), .irq(irq), .ien(ien_q), .stat(stat_q),
  .peer_rst(peer_rst), .ovr_evt(tx_ovr),
  .und_rd(bus_rd && (bus_addr == 4'd9) && (rx_occ_q == '0)),
  .bus_rdata(bus_rdata)
);

// File: tb/test_mmstream_fifo.sv
`timescale 1ns/1ps
module test_mmstream_fifo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  logic        tx_tvalid, tx_tlast;
  logic        tx_tready = 1'b1;
  logic [31:0] tx_tdata;
  logic [3:0]  tx_tkeep, tx_tdest;
  logic        rx_tvalid = 1'b0, rx_tlast = 1'b0;
  logic        rx_tready;
  logic [31:0] rx_tdata = '0;
  logic [3:0]  rx_tkeep = '0, rx_tdest = '0;
  logic        peer_rst;

  int n_chk = 0, n_bad = 0;
  logic [31:0] cap_d [32];
  logic [3:0]  cap_k [32];
  logic        cap_l [32];
  logic [3:0]  cap_t [32];
  int cap_n = 0;
  int pulses = 0;
  logic [31:0] rv;

  always #10 clk = ~clk;

  mmstream_fifo i_mmstream_fifo (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .tx_tvalid(tx_tvalid), .tx_tready(tx_tready), .tx_tdata(tx_tdata),
    .tx_tkeep(tx_tkeep), .tx_tlast(tx_tlast), .tx_tdest(tx_tdest),
    .rx_tvalid(rx_tvalid), .rx_tready(rx_tready), .rx_tdata(rx_tdata),
    .rx_tkeep(rx_tkeep), .rx_tlast(rx_tlast), .rx_tdest(rx_tdest),
    .peer_rst(peer_rst)
  );

  // outputs are stable at the falling edge; inputs change 1 ns after the rising edge
  always @(negedge clk) begin
    if (rst_n && tx_tvalid && tx_tready && cap_n < 32) begin
      cap_d[cap_n] = tx_tdata; cap_k[cap_n] = tx_tkeep;
      cap_l[cap_n] = tx_tlast; cap_t[cap_n] = tx_tdest;
      cap_n++;
    end
    if (peer_rst) pulses++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bwr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic brd(input logic [3:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); #1;
    bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic rx_beat(input logic [31:0] d, input logic [3:0] k,
                         input logic l, input logic [3:0] t);
    @(posedge clk); #1;
    rx_tvalid = 1'b1; rx_tdata = d; rx_tkeep = k; rx_tlast = l; rx_tdest = t;
    @(negedge clk);
    while (!rx_tready) @(negedge clk);
    @(posedge clk); #1;
    rx_tvalid = 1'b0;
  endtask

  task automatic clear_stat();
    bwr(4'd0, 32'h3F);
  endtask

  task automatic t_reset();
    chk("R8 irq after reset", 32'(irq), 0);
    chk("R11 tvalid after reset", 32'(tx_tvalid), 0);
    brd(4'd0, rv); chk("R7 status after reset", rv, 0);
    brd(4'd4, rv); chk("R3 vacancy after reset", rv, 16);
    brd(4'd8, rv); chk("R3 occupancy after reset", rv, 0);
    brd(4'd13, rv); chk("R12 unmapped read", rv, 0);
    bwr(4'd1, 32'h2A); brd(4'd1, rv); chk("R12 enable readback", rv, 32'h2A);
    bwr(4'd1, 32'h0);
  endtask

  task automatic t_tx_basic();
    clear_stat(); cap_n = 0; tx_tready = 1'b1;
    bwr(4'd6, 32'h35);
    bwr(4'd3, 32'h11110000); bwr(4'd3, 32'h22220000); bwr(4'd3, 32'h00003333);
    brd(4'd4, rv); chk("R3 vacancy after three words", rv, 13);
    bwr(4'd5, 32'd10);
    repeat (8) @(posedge clk);
    chk("R1 beat count", 32'(cap_n), 3);
    chk("R1 beat0 data", cap_d[0], 32'h11110000);
    chk("R1 beat2 data", cap_d[2], 32'h00003333);
    chk("R2 beat0 keep", 32'(cap_k[0]), 4'hF);
    chk("R2 beat2 keep", 32'(cap_k[2]), 4'h3);
    chk("R2 beat1 last", 32'(cap_l[1]), 0);
    chk("R2 beat2 last", 32'(cap_l[2]), 1);
    chk("R1 tdest", 32'(cap_t[1]), 4'h5);
    brd(4'd6, rv); chk("R1 dest readback", rv, 5);
    brd(4'd0, rv); chk("R7 send done bit", rv & 32'h1, 1);
    bwr(4'd0, 32'h1); brd(4'd0, rv); chk("R7 write-one clear", rv & 32'h1, 0);
    brd(4'd4, rv); chk("R3 vacancy after send", rv, 16);
  endtask

  task automatic t_tx_backpressure();
    cap_n = 0; tx_tready = 1'b0;
    bwr(4'd6, 32'hC); bwr(4'd3, 32'hAAAA5555); bwr(4'd3, 32'h00BBCCDD);
    bwr(4'd5, 32'd7);
    repeat (5) @(posedge clk);
    chk("R11 no beat while stalled", 32'(cap_n), 0);
    chk("R11 valid while stalled", 32'(tx_tvalid), 1);
    for (int i = 0; i < 8; i++) begin
      @(posedge clk); #1; tx_tready = ~tx_tready;
    end
    tx_tready = 1'b1;
    repeat (3) @(posedge clk);
    chk("R11 beats after stall", 32'(cap_n), 2);
    chk("R11 stalled data kept", cap_d[0], 32'hAAAA5555);
    chk("R2 seven byte tail keep", 32'(cap_k[1]), 4'h7);
    chk("R1 dest low bits", 32'(cap_t[1]), 4'hC);
  endtask

  task automatic t_tx_zero();
    cap_n = 0;
    bwr(4'd5, 32'd0);
    repeat (6) @(posedge clk);
    chk("R1 zero length sends nothing", 32'(cap_n), 0);
  endtask

  task automatic t_tx_overrun_flush();
    clear_stat(); tx_tready = 1'b0; cap_n = 0;
    rx_beat(32'h77, 4'hF, 1'b1, 4'd0);
    for (int i = 0; i < 17; i++) bwr(4'd3, 32'(i));
    brd(4'd4, rv); chk("R4 vacancy full", rv, 0);
    brd(4'd0, rv); chk("R4 overrun bit", rv & 32'h20, 32'h20);
    bwr(4'd2, 32'h5A);
    brd(4'd4, rv); chk("R9 wrong key ignored", rv, 0);
    bwr(4'd2, 32'hA5);
    brd(4'd4, rv); chk("R9 send flush empties", rv, 16);
    brd(4'd0, rv); chk("R9 send flush bit", rv & 32'hC, 32'h4);
    brd(4'd8, rv); chk("R9 receive untouched", rv, 1);
    tx_tready = 1'b1; repeat (4) @(posedge clk);
    chk("R9 nothing sent after flush", 32'(cap_n), 0);
    brd(4'd10, rv); brd(4'd9, rv); chk("R9 receive word kept", rv, 32'h77);
  endtask

  task automatic t_rx_basic();
    clear_stat();
    rx_beat(32'hDEAD0001, 4'hF, 1'b0, 4'd9);
    rx_beat(32'hDEAD0002, 4'hF, 1'b0, 4'd9);
    brd(4'd8, rv); chk("R3 partial frame not counted", rv, 0);
    rx_beat(32'h0000BEEF, 4'h3, 1'b1, 4'd9);
    brd(4'd8, rv); chk("R3 occupancy three", rv, 3);
    brd(4'd0, rv); chk("R7 receive done bit", rv & 32'h2, 2);
    brd(4'd10, rv); chk("R5 length in bytes", rv, 10);
    brd(4'd11, rv); chk("R5 destination", rv, 9);
    brd(4'd9, rv); chk("R5 word0", rv, 32'hDEAD0001);
    brd(4'd9, rv); chk("R5 word1", rv, 32'hDEAD0002);
    brd(4'd9, rv); chk("R5 word2", rv, 32'h0000BEEF);
    brd(4'd9, rv); chk("R6 empty data read", rv, 0);
    brd(4'd0, rv); chk("R6 underrun bit", rv & 32'h10, 32'h10);
  endtask

  task automatic t_rx_two();
    rx_beat(32'h000000AB, 4'h1, 1'b1, 4'd1);
    rx_beat(32'h10101010, 4'hF, 1'b0, 4'd2);
    rx_beat(32'h20202020, 4'hF, 1'b1, 4'd2);
    brd(4'd8, rv); chk("R3 occupancy two frames", rv, 3);
    brd(4'd10, rv); chk("R5 first length", rv, 1);
    brd(4'd11, rv); chk("R5 first dest", rv, 1);
    brd(4'd9, rv); chk("R5 first word", rv, 32'hAB);
    brd(4'd10, rv); chk("R5 second length", rv, 8);
    brd(4'd11, rv); chk("R5 dest advances", rv, 2);
    brd(4'd9, rv); brd(4'd9, rv); chk("R5 second frame tail", rv, 32'h20202020);
    clear_stat();
    brd(4'd10, rv); chk("R6 length with no frame", rv, 0);
    brd(4'd0, rv); chk("R6 underrun on length", rv & 32'h10, 32'h10);
  endtask

  task automatic t_irq();
    clear_stat(); bwr(4'd1, 32'h0);
    rx_beat(32'h5, 4'hF, 1'b1, 4'd3);
    @(negedge clk); chk("R8 masked irq", 32'(irq), 0);
    bwr(4'd1, 32'h2);
    @(negedge clk); chk("R8 enabled irq", 32'(irq), 1);
    bwr(4'd0, 32'h2);
    @(negedge clk); chk("R8 irq after clear", 32'(irq), 0);
    bwr(4'd1, 32'h0);
  endtask

  task automatic t_rx_flush();
    bwr(4'd7, 32'hA4);
    brd(4'd8, rv); chk("R9 receive wrong key ignored", rv, 1);
    clear_stat();
    bwr(4'd7, 32'hA5);
    brd(4'd8, rv); chk("R9 receive flush empties", rv, 0);
    brd(4'd0, rv); chk("R9 receive flush bit", rv & 32'hC, 32'h8);
    brd(4'd10, rv); chk("R9 no frame after flush", rv, 0);
  endtask

  task automatic t_stream_reset();
    clear_stat(); tx_tready = 1'b0; pulses = 0;
    bwr(4'd3, 32'h1); bwr(4'd3, 32'h2);
    rx_beat(32'h9, 4'hF, 1'b1, 4'd4);
    bwr(4'd12, 32'hA5);
    repeat (3) @(posedge clk);
    chk("R10 one reset pulse", 32'(pulses), 1);
    brd(4'd4, rv); chk("R10 send flushed", rv, 16);
    brd(4'd8, rv); chk("R10 receive flushed", rv, 0);
    brd(4'd0, rv); chk("R10 both flush bits", rv & 32'hC, 32'hC);
    tx_tready = 1'b1;
  endtask

  initial begin
    repeat (3) @(posedge clk); #1; rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_reset();
    t_tx_basic();
    t_tx_backpressure();
    t_tx_zero();
    t_tx_overrun_flush();
    t_rx_basic();
    t_rx_two();
    t_irq();
    t_rx_flush();
    t_stream_reset();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule